// File: doc/BRIEF.md
# Vectored Interrupt Handler-Address Fetch Sequencer

This block runs the entry sequence for a hardware-vectored interrupt. Once an enabled interrupt is pending, it computes the address of that interrupt's slot in a handler table in memory. It reads the slot through a single read port and then loads the fetched handler address into the PC. The interrupt's pending bit is acknowledged only after that read succeeds.

If the table read returns a fault, no handler jump takes place. The sequencer raises an exception trap instead. It writes the trap CSRs and redirects the PC to the exception vector. Two recording schemes are offered, and the mode input chooses between them when the trap is entered.

- In the flagged scheme, the cause register gets a marker bit, and epc holds the faulting table slot address.
- In the alternate scheme, the marker bit stays clear, epc keeps the address of the next instruction of the interrupted code, and tval carries the faulting slot address.

After a fault the sequencer waits for the return from the exception handler. The interrupt is still pending at that point, so the sequencer takes it again and repeats the table read.

Top module: `vtrap_seq`

## Requirements
- R1: When `irq_valid_i` is high in the idle state, `mem_req_o` rises in the next cycle with `mem_addr_o` = `tbl_base_i` + `irq_id_i`*4. Both stay stable until the cycle in which `mem_rvalid_i` is seen high.
- R2: On a response without fault, in the next cycle the block holds `pc_load_o` high for one cycle. `pc_target_o` equals `mem_rdata_i` with bit 0 cleared, and `irq_ack_o` is high for that cycle with `irq_ack_id_o` equal to the interrupt ID.
- R3: On a faulting response, in the next cycle the block asserts `csr_we_o` and `pc_load_o` for one cycle, with `pc_target_o` = `exc_vec_i`. It does not assert `irq_ack_o`.
- R4: On a fault, `cause_o` bit 31 is 0 (exception). Bits 4:0 are 13 when `mem_fault_page_i` was high and 5 otherwise. All other bits are 0 except bit 30.
- R5: In flagged mode (`alt_mode_i`=0 at entry), a fault sets `cause_o` bit 30, and both `epc_o` and `tval_o` equal the table slot address.
- R6: In alternate mode (`alt_mode_i`=1 at entry), `cause_o` bit 30 is 0. `epc_o` equals the `pc_i` value captured at entry, and `tval_o` equals the table slot address.
- R7: After a fault, the block issues no memory request while it waits, even with `irq_valid_i` high. Once `xret_i` is seen high, it returns to idle. If the interrupt is still pending, it starts a new table read at the same address in the following cycle.
- R8: With `irq_valid_i` low in idle, the block drives `mem_req_o`, `pc_load_o`, `csr_we_o` and `irq_ack_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_valid_i | input | 1 | Enabled interrupt pending |
| irq_id_i | input | ID_W | ID of the pending interrupt |
| pc_i | input | XLEN | Next instruction address of the interrupted code |
| tbl_base_i | input | XLEN | Handler table base, slot aligned |
| exc_vec_i | input | XLEN | Exception handler entry address |
| alt_mode_i | input | 1 | 1 selects the alternate fault scheme |
| xret_i | input | 1 | Return from the exception handler |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | XLEN | Table slot address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | XLEN | Read data (handler address) |
| mem_fault_i | input | 1 | Response is a fault |
| mem_fault_page_i | input | 1 | Fault is a page fault (else access fault) |
| pc_load_o | output | 1 | Load `pc_target_o` into the PC |
| pc_target_o | output | XLEN | New PC |
| csr_we_o | output | 1 | Write epc, cause and tval |
| epc_o | output | XLEN | epc value |
| cause_o | output | XLEN | cause value |
| tval_o | output | XLEN | tval value |
| irq_ack_o | output | 1 | Clear the pending bit |
| irq_ack_id_o | output | ID_W | ID whose pending bit is cleared |

## Verification
A pending interrupt sampled at an edge shows as a read request in the half cycle after that edge. A memory response sampled at an edge shows as either a PC load or a CSR write in the half cycle after that edge, and those outputs are gone one edge later. An `xret_i` sampled at an edge is followed by a fresh request one edge after that. The bench drives every input at the falling edge and samples the outputs at the next falling edge, exactly the number of edges listed above after the stimulus. It also checks that the request stays steady through randomly drawn response latencies.

// File: rtl/vtrap_pkg.sv
package vtrap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_JUMP,
    ST_FAULT,
    ST_HOLD
  } state_e;

  localparam logic [4:0] CODE_LD_ACCESS = 5'd5;
  localparam logic [4:0] CODE_LD_PAGE   = 5'd13;
endpackage

// File: rtl/vtrap_addr.sv
module vtrap_addr #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned ID_W = 5
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [ID_W-1:0] id_i,
  output logic [XLEN-1:0] addr_o
);
  localparam int unsigned SLOT_BYTES = XLEN / 8;
  localparam int unsigned SHIFT      = $clog2(SLOT_BYTES);

  logic [XLEN-1:0] id_ext;
  assign id_ext = {{(XLEN-ID_W){1'b0}}, id_i};
  assign addr_o = base_i + (id_ext << SHIFT);
endmodule

// File: rtl/vtrap_fsm.sv
module vtrap_fsm
  import vtrap_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   irq_valid_i,
  input  logic   rvalid_i,
  input  logic   fault_i,
  input  logic   xret_i,
  output state_e state_o,
  output logic   enter_o,
  output logic   resp_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (irq_valid_i) state_d = ST_FETCH;
      ST_FETCH: if (rvalid_i) state_d = fault_i ? ST_FAULT : ST_JUMP;
      ST_JUMP:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_HOLD;
      ST_HOLD:  if (xret_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign enter_o = (state_q == ST_IDLE) && irq_valid_i;
  assign resp_o  = (state_q == ST_FETCH) && rvalid_i;
endmodule

// File: rtl/vtrap_csr.sv
module vtrap_csr
  import vtrap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            alt_i,
  input  logic            page_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] slot_i,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] tval_o
);
  always_comb begin
    cause_o         = '0;
    cause_o[4:0]    = page_i ? CODE_LD_PAGE : CODE_LD_ACCESS;
    cause_o[XLEN-2] = !alt_i;  // marker: epc holds a table slot address
    epc_o           = alt_i ? pc_i : slot_i;
    tval_o          = slot_i;
  end
endmodule

// File: rtl/vtrap_seq.sv
module vtrap_seq
  import vtrap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned ID_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_valid_i,
  input  logic [ID_W-1:0] irq_id_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] tbl_base_i,
  input  logic [XLEN-1:0] exc_vec_i,
  input  logic            alt_mode_i,
  input  logic            xret_i,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_fault_i,
  input  logic            mem_fault_page_i,
  output logic            pc_load_o,
  output logic [XLEN-1:0] pc_target_o,
  output logic            csr_we_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] tval_o,
  output logic            irq_ack_o,
  output logic [ID_W-1:0] irq_ack_id_o
);
  state_e          state;
  logic            enter, resp;
  logic [XLEN-1:0] slot_addr;
  logic [XLEN-1:0] slot_q, pc_q, handler_q;
  logic [ID_W-1:0] id_q;
  logic            alt_q, page_q;

  vtrap_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_valid_i(irq_valid_i),
    .rvalid_i   (mem_rvalid_i),
    .fault_i    (mem_fault_i),
    .xret_i     (xret_i),
    .state_o    (state),
    .enter_o    (enter),
    .resp_o     (resp)
  );

  vtrap_addr #(.XLEN(XLEN), .ID_W(ID_W)) u_addr (
    .base_i(tbl_base_i),
    .id_i  (irq_id_i),
    .addr_o(slot_addr)
  );

  vtrap_csr #(.XLEN(XLEN)) u_csr (
    .alt_i  (alt_q),
    .page_i (page_q),
    .pc_i   (pc_q),
    .slot_i (slot_q),
    .epc_o  (epc_o),
    .cause_o(cause_o),
    .tval_o (tval_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q    <= '0;
      pc_q      <= '0;
      id_q      <= '0;
      alt_q     <= 1'b0;
      page_q    <= 1'b0;
      handler_q <= '0;
    end else begin
      if (enter) begin
        slot_q <= slot_addr;
        pc_q   <= pc_i;
        id_q   <= irq_id_i;
        alt_q  <= alt_mode_i;
      end
      if (resp) begin
        page_q    <= mem_fault_page_i;
        handler_q <= {mem_rdata_i[XLEN-1:1], 1'b0};
      end
    end
  end

  assign mem_req_o    = (state == ST_FETCH);
  assign mem_addr_o   = slot_q;
  assign pc_load_o    = (state == ST_JUMP) || (state == ST_FAULT);
  assign pc_target_o  = (state == ST_FAULT) ? exc_vec_i : handler_q;
  assign csr_we_o     = (state == ST_FAULT);
  assign irq_ack_o    = (state == ST_JUMP);
  assign irq_ack_id_o = id_q;
endmodule

// File: rtl/vtrap_seq_chk.sv
module vtrap_seq_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic            mem_rvalid_i,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            pc_load_o,
  input logic [XLEN-1:0] pc_target_o,
  input logic            csr_we_o,
  input logic [XLEN-1:0] cause_o,
  input logic [XLEN-1:0] epc_o,
  input logic [XLEN-1:0] tval_o,
  input logic            irq_ack_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)) else $error("AST_REQ_HELD"); // R1
  AST_HANDLER_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o && !csr_we_o |-> !pc_target_o[0]) else $error("AST_HANDLER_EVEN"); // R2
  AST_FAULT_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_o |-> pc_load_o && !irq_ack_o) else $error("AST_FAULT_NO_ACK"); // R3
  AST_FAULT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_o |=> !csr_we_o && !mem_req_o) else $error("AST_FAULT_PULSE"); // R7
  AST_CAUSE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_o |-> !cause_o[XLEN-1] && (cause_o[4:0] == 5'd5 || cause_o[4:0] == 5'd13)) else $error("AST_CAUSE_CODE"); // R4
  AST_MARK_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_o && cause_o[XLEN-2] |-> epc_o == tval_o) else $error("AST_MARK_EPC"); // R5
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pc_load_o && !irq_ack_o) else $error("AST_REQ_EXCL"); // R8
endmodule

bind vtrap_seq vtrap_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_rvalid_i(mem_rvalid_i),
  .mem_addr_o  (mem_addr_o),
  .pc_load_o   (pc_load_o),
  .pc_target_o (pc_target_o),
  .csr_we_o    (csr_we_o),
  .cause_o     (cause_o),
  .epc_o       (epc_o),
  .tval_o      (tval_o),
  .irq_ack_o   (irq_ack_o)
);

// File: tb/vtrap_seq_tb_top.sv
module vtrap_seq_tb_top;
  localparam int unsigned XLEN = 32;
  localparam int unsigned ID_W = 5;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            irq_valid_i = 1'b0;
  logic [ID_W-1:0] irq_id_i = '0;
  logic [XLEN-1:0] pc_i = '0, tbl_base_i = '0, exc_vec_i = '0;
  logic            alt_mode_i = 1'b0, xret_i = 1'b0;
  logic            mem_req_o;
  logic [XLEN-1:0] mem_addr_o;
  logic            mem_rvalid_i = 1'b0;
  logic [XLEN-1:0] mem_rdata_i = '0;
  logic            mem_fault_i = 1'b0, mem_fault_page_i = 1'b0;
  logic            pc_load_o;
  logic [XLEN-1:0] pc_target_o;
  logic            csr_we_o;
  logic [XLEN-1:0] epc_o, cause_o, tval_o;
  logic            irq_ack_o;
  logic [ID_W-1:0] irq_ack_id_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  vtrap_seq #(.XLEN(XLEN), .ID_W(ID_W)) dut_i (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [XLEN-1:0] slot_of(logic [XLEN-1:0] b, logic [ID_W-1:0] id);
    return b + XLEN'(id) * 4;
  endfunction

  function automatic logic [XLEN-1:0] cause_of(bit alt, bit page);
    logic [XLEN-1:0] c = '0;
    c[4:0]  = page ? 5'd13 : 5'd5;
    c[30]   = !alt;
    return c;
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet(string req);
    chk(req, {mem_req_o, pc_load_o, csr_we_o, irq_ack_o}, 4'b0000);
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // one trap entry; caller holds irq stimulus; returns after completion
  task automatic do_trap(logic [ID_W-1:0] id, logic [XLEN-1:0] pc, logic [XLEN-1:0] base,
                         bit alt, bit fault, bit page, logic [XLEN-1:0] hdl, int lat);
    logic [XLEN-1:0] slot = slot_of(base, id);
    irq_id_i = id; pc_i = pc; tbl_base_i = base; alt_mode_i = alt; irq_valid_i = 1'b1;
    tick();
    chk("R1 req", mem_req_o, 1'b1);
    chk("R1 addr", mem_addr_o, slot);
    for (int i = 0; i < lat; i++) begin
      tick();
      chk("R1 held", {mem_req_o, mem_addr_o}, {1'b1, slot});
    end
    // inputs that change after capture must not matter
    pc_i = ~pc; tbl_base_i = ~base; alt_mode_i = !alt;
    mem_rvalid_i = 1'b1; mem_fault_i = fault; mem_fault_page_i = page; mem_rdata_i = hdl;
    tick();
    mem_rvalid_i = 1'b0; mem_fault_i = 1'b0;
    if (!fault) begin
      chk("R2 load", {pc_load_o, csr_we_o, irq_ack_o}, 3'b101);
      chk("R2 target", pc_target_o, {hdl[XLEN-1:1], 1'b0});
      chk("R2 ack id", irq_ack_id_o, id);
      irq_valid_i = 1'b0;
      tick();
      quiet("R8 idle");
    end else begin
      chk("R3 trap", {pc_load_o, csr_we_o, irq_ack_o}, 3'b110);
      chk("R3 vector", pc_target_o, exc_vec_i);
      chk(alt ? "R6 cause" : "R5 R4 cause", cause_o, cause_of(alt, page));
      chk(alt ? "R6 epc" : "R5 epc", epc_o, alt ? pc : slot);
      chk(alt ? "R6 tval" : "R5 tval", tval_o, slot);
      tick();
      quiet("R7 wait");
      tick();
      quiet("R7 wait2");
      tbl_base_i = base; irq_id_i = id;
      xret_i = 1'b1;
      tick();
      xret_i = 1'b0;
      quiet("R7 ret idle");
      tick();
      chk("R7 refetch", {mem_req_o, mem_addr_o}, {1'b1, slot});
      mem_rvalid_i = 1'b1; mem_rdata_i = hdl;
      tick();
      mem_rvalid_i = 1'b0;
      chk("R7 retaken ack", {pc_load_o, irq_ack_o}, 2'b11);
      irq_valid_i = 1'b0;
      tick();
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    exc_vec_i = 32'h0000_0100;
    repeat (3) tick();
    quiet("R8 reset");
    rst_ni = 1'b1;
    tick();
    tick();
    quiet("R8 idle");
    // directed corners
    do_trap(5'd0, 32'h8000_0010, 32'h0001_0000, 1'b0, 1'b0, 1'b0, 32'h2000_0001, 0);
    do_trap(5'd31, 32'h8000_0020, 32'h0001_0000, 1'b0, 1'b1, 1'b0, 32'h2000_0000, 2);
    do_trap(5'd7, 32'h8000_0030, 32'h0002_0000, 1'b1, 1'b1, 1'b1, 32'h3000_0003, 1);
    do_trap(5'd3, 32'h8000_0040, 32'h0002_0000, 1'b0, 1'b1, 1'b1, 32'h3000_0004, 0);
    do_trap(5'd9, 32'h8000_0050, 32'h0003_0000, 1'b1, 1'b1, 1'b0, 32'h3000_0005, 3);
    // random
    for (int n = 0; n < 60; n++) begin
      do_trap(ID_W'($urandom), $urandom, $urandom & 32'hFFFF_FF80, 1'($urandom),
              ($urandom % 3) == 0, 1'($urandom), $urandom, int'($urandom % 5));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule